// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches 32 general-purpose input pins and turns activity on them into one interrupt request for a processor. The pins form two banks of 16: a low bank (pins 0 to 15) and a high bank (pins 16 to 31). Each pin has its own settings. It can be level or edge sensitive. An edge-sensitive pin can either latch its event or pass it straight through. The pin can react to falling edges, rising edges or both.

Software programs the unit through a word-wide synchronous register port. It reads a per-bank status word and clears latched events by writing ones to that word. The unit combines the enabled pending pins into `irq_o`. It also reports the number of the pin to serve first: the lowest pending pin of the low bank, or, only when the low bank has none, the lowest pending pin of the high bank. Each input passes through a synchroniser before detection.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration word (enable, type, hold, falling, rising) reads 0 and `irq_o` is low.
- R2: Register address = {field[2:0], bank}, with bank 0 = low and bank 1 = high. Field 0 = status, 1 = enable, 2 = type, 3 = hold, 4 = falling-edge enable, 5 = rising-edge enable. Fields 6 and 7 read 0. A write takes effect at the clock edge on which `wr_en_i` is sampled. `rdata_o` presents the addressed word one clock after the address is sampled.
- R3: A pin with type bit 0 is level sensitive and active high. Its status bit equals the pin value two clocks after the pin changes. Writing 1 to that status bit has no effect.
- R4: A pin with type 1 and hold 1 sets its status bit on a selected edge. The bit stays set until software writes 1 to it. Writing 0 leaves it set.
- R5: A pin with type 1 and hold 0 shows its status bit, and its pending state, for exactly one clock per selected edge. The pulse starts two clocks after the pin changes.
- R6: An edge-sensitive pin reacts as follows: falling edges only when only its falling-edge enable is set; rising edges only when only its rising-edge enable is set; both edges when both are set; no edges when neither is set.
- R7: A pin is pending only when its status bit and its enable bit are both 1. `irq_o` is high exactly when some pin is pending.
- R8: While `irq_o` is high, `irq_idx_o` gives the lowest pending pin of the low bank. When no low pin is pending, it gives 16 plus the lowest pending index of the high bank.
- R9: If a selected edge on a latched pin occurs in the same clock as a write of 1 to its status bit, the bit stays set.
- R10: Reading a register changes no status or configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 32 | Asynchronous pin inputs, bit n = pin n |
| addr_i | input | 4 | Register address {field, bank} |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt; also marks `irq_idx_o` valid |
| irq_idx_o | output | 5 | Number of the pin to serve first |

## Verification
The hardest case to reach from the ports is a new edge on a latched pin that lands in the same clock as a write-one-to-clear of that bit. The pin change must be timed through the two synchroniser stages. The bench moves the pin on a falling clock edge, lets exactly two rising edges pass, and then issues the clear write. The detected edge and the clear then meet at the same rising edge. A plain clear without an edge follows, to show that the clear itself works. Priority is swept over every pair of level-active pins and over every single-pin enable mask. The one-clock pass-through pulse is swept over all 32 pins.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and types of the GPIO interrupt detection unit.
// Assumes two banks; the address is {field, bank}.
package gpio_irq_pkg;
    localparam int BANK_W     = 16;
    localparam int NUM_BANKS  = 2;
    localparam int NUM_PINS   = BANK_W * NUM_BANKS;
    localparam int IDX_W      = $clog2(NUM_PINS);
    localparam int BIDX_W     = $clog2(BANK_W);
    localparam int BANK_SEL_W = $clog2(NUM_BANKS);
    localparam int FIELD_W    = 3;
    localparam int ADDR_W     = FIELD_W + BANK_SEL_W;

    typedef enum logic [FIELD_W-1:0] {
        F_STAT = 3'd0,
        F_EN   = 3'd1,
        F_TYPE = 3'd2,
        F_HOLD = 3'd3,
        F_FALL = 3'd4,
        F_RISE = 3'd5
    } field_e;

    typedef struct packed {
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] typ;
        logic [BANK_W-1:0] hold;
        logic [BANK_W-1:0] fall;
        logic [BANK_W-1:0] rise;
    } bank_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is sampled on its own; there is no bus coherence across bits.
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage copies the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_bank.sv
// Edge/level detection and status for one bank of pins.
// Assumes cur_i is already synchronised. clr_i carries the write-one-to-clear mask
// of the current cycle. A latch is kept only while the pin is in edge-hold mode.
module gpio_irq_bank
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cur_i,
    input  bank_cfg_t         cfg_i,
    input  logic [BANK_W-1:0] clr_i,
    output logic [BANK_W-1:0] stat_o,
    output logic [BANK_W-1:0] pend_o
);
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] latch_q;
    logic [BANK_W-1:0] evt;
    logic [BANK_W-1:0] held;

    assign evt  = (cur_i & ~prev_q & cfg_i.rise) | (~cur_i & prev_q & cfg_i.fall);
    assign held = cfg_i.typ & cfg_i.hold;

    // Remember the synchronised value of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_i;
    end

    // Latched events: a new edge beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= ((latch_q & ~clr_i) | evt) & held;
    end

    // Status view per mode: level, latched edge, or pass-through edge.
    always_comb begin
        stat_o = (~cfg_i.typ & cur_i) | (held & latch_q) | (cfg_i.typ & ~cfg_i.hold & evt);
        pend_o = stat_o & cfg_i.en;
    end

    a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(latch_q & ~clr_i & held) & held & ~latch_q) == '0));

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt & clr_i & held) & held & ~latch_q) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
// Configuration registers, clear strobes and registered read-back.
// Assumes address = {field, bank}; unused fields read zero; reads have no side effects.
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [BANK_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] stat_i [NUM_BANKS],
    output bank_cfg_t         cfg_o  [NUM_BANKS],
    output logic [BANK_W-1:0] clr_o  [NUM_BANKS],
    output logic [BANK_W-1:0] rdata_o
);
    logic [BANK_SEL_W-1:0] sel;
    field_e                fld;

    assign sel = addr_i[BANK_SEL_W-1:0];
    assign fld = field_e'(addr_i[ADDR_W-1:BANK_SEL_W]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Write the addressed configuration word of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[b] <= '0;
            end else if (wr_en_i && sel == BANK_SEL_W'(b)) begin
                case (fld)
                    F_EN:    cfg_o[b].en   <= wdata_i;
                    F_TYPE:  cfg_o[b].typ  <= wdata_i;
                    F_HOLD:  cfg_o[b].hold <= wdata_i;
                    F_FALL:  cfg_o[b].fall <= wdata_i;
                    F_RISE:  cfg_o[b].rise <= wdata_i;
                    default: ;
                endcase
            end
        end

        // Present the write-one-to-clear mask for this bank's status.
        assign clr_o[b] = (wr_en_i && sel == BANK_SEL_W'(b) && fld == F_STAT) ? wdata_i : '0;
    end

    // Capture the addressed word for read-back one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else begin
            case (fld)
                F_STAT:  rdata_o <= stat_i[sel];
                F_EN:    rdata_o <= cfg_o[sel].en;
                F_TYPE:  rdata_o <= cfg_o[sel].typ;
                F_HOLD:  rdata_o <= cfg_o[sel].hold;
                F_FALL:  rdata_o <= cfg_o[sel].fall;
                F_RISE:  rdata_o <= cfg_o[sel].rise;
                default: rdata_o <= '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_prio.sv
// Fixed-priority selection of the pin to serve: lowest bank first, lowest bit first.
// Assumes pend_i is ordered with pin n at bit n; purely combinational apart from checks.
module gpio_irq_prio
    import gpio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pend_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o
);
    logic [NUM_BANKS-1:0] bank_any;
    logic [BIDX_W-1:0]    bank_idx [NUM_BANKS];
    logic [NUM_PINS-1:0]  below;

    function automatic logic [BIDX_W-1:0] lowest(input logic [BANK_W-1:0] v);
        lowest = '0;
        for (int i = BANK_W - 1; i >= 0; i--) begin
            if (v[i]) lowest = i[BIDX_W-1:0];
        end
    endfunction

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_enc
        assign bank_any[b] = |pend_i[b*BANK_W +: BANK_W];
        assign bank_idx[b] = lowest(pend_i[b*BANK_W +: BANK_W]);
    end

    // Pick the first bank with a pending pin and offset its local index.
    always_comb begin
        any_o = |bank_any;
        idx_o = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bank_any[b]) idx_o = IDX_W'(b * BANK_W) + IDX_W'(bank_idx[b]);
        end
    end

    assign below = (NUM_PINS'(1) << idx_o) - NUM_PINS'(1);

    a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (pend_i[idx_o] && ((pend_i & below) == '0)));

    a_r7_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !any_o |-> (pend_i == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
// GPIO interrupt detection unit: synchronises pins, detects per-pin events,
// keeps status, masks with enables and reports one prioritised interrupt.
// Assumes a single clock domain for the register port; pins may be asynchronous.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [BANK_W-1:0]   wdata_i,
    output logic [BANK_W-1:0]   rdata_o,
    output logic                irq_o,
    output logic [IDX_W-1:0]    irq_idx_o
);
    logic [NUM_PINS-1:0] pins_s;
    logic [NUM_PINS-1:0] pend_all;
    logic [BANK_W-1:0]   stat [NUM_BANKS];
    logic [BANK_W-1:0]   clr  [NUM_BANKS];
    bank_cfg_t           cfg  [NUM_BANKS];

    gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_s)
    );

    gpio_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .stat_i(stat), .cfg_o(cfg), .clr_o(clr), .rdata_o(rdata_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_irq_bank u_bank (
            .clk(clk), .rst_n(rst_n), .cur_i(pins_s[b*BANK_W +: BANK_W]),
            .cfg_i(cfg[b]), .clr_i(clr[b]), .stat_o(stat[b]),
            .pend_o(pend_all[b*BANK_W +: BANK_W])
        );
    end

    gpio_irq_prio u_prio (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_all), .any_o(irq_o), .idx_o(irq_idx_o)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !irq_o);
endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_STAT_LO = 4'd0,  A_STAT_HI = 4'd1;
    localparam logic [3:0] A_EN_LO   = 4'd2,  A_EN_HI   = 4'd3;
    localparam logic [3:0] A_TYPE_LO = 4'd4,  A_TYPE_HI = 4'd5;
    localparam logic [3:0] A_HOLD_LO = 4'd6,  A_HOLD_HI = 4'd7;
    localparam logic [3:0] A_FALL_LO = 4'd8,  A_FALL_HI = 4'd9;
    localparam logic [3:0] A_RISE_LO = 4'd10, A_RISE_HI = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [4:0]  idx;
    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_unit u_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr), .wr_en_i(we),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_idx_o(idx)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        step(1);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        step(1);
        d = rdata;
    endtask

    task automatic cfg_all(input logic [15:0] en, typ, hold, fall, rise);
        wr(A_EN_LO, en);     wr(A_EN_HI, en);
        wr(A_TYPE_LO, typ);  wr(A_TYPE_HI, typ);
        wr(A_HOLD_LO, hold); wr(A_HOLD_HI, hold);
        wr(A_FALL_LO, fall); wr(A_FALL_HI, fall);
        wr(A_RISE_LO, rise); wr(A_RISE_HI, rise);
    endtask

    function automatic int low_of(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 0;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] d2;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        chk("R1 irq", irq, 0);
        rd(A_EN_LO, d);   chk("R1 en_lo", d, 0);
        rd(A_EN_HI, d);   chk("R1 en_hi", d, 0);
        rd(A_TYPE_HI, d); chk("R1 type_hi", d, 0);
        rd(A_RISE_LO, d); chk("R1 rise_lo", d, 0);

        // R2: map, independence of banks, unused fields
        wr(A_EN_LO, 16'hA5C3);
        wr(A_HOLD_HI, 16'h3C5A);
        rd(A_EN_LO, d);   chk("R2 en_lo", d, 16'hA5C3);
        rd(A_EN_HI, d);   chk("R2 en_hi", d, 0);
        rd(A_HOLD_HI, d); chk("R2 hold_hi", d, 16'h3C5A);
        rd(4'd14, d);     chk("R2 unused", d, 0);
        wr(A_HOLD_HI, 16'h0000);

        // R3: level mode status follows pins, clear has no effect
        cfg_all(16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        pins = 32'h00F0_1234;
        step(1);
        chk("R3 not yet", irq, 0);
        step(1);
        chk("R3 irq", irq, 1);
        rd(A_STAT_LO, d); chk("R3 stat_lo", d, 16'h1234);
        rd(A_STAT_HI, d); chk("R3 stat_hi", d, 16'h00F0);
        wr(A_STAT_LO, 16'hFFFF);
        rd(A_STAT_LO, d); chk("R3 clear ignored", d, 16'h1234);

        // R8: every pair of active level pins, lowest wins (low bank first)
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 32; j++) begin
                pins = (32'd1 << i) | (32'd1 << j);
                step(2);
                chk("R8 pair irq", irq, 1);
                chk("R8 pair idx", idx, (i < j) ? i : j);
            end
        end
        pins = '0; step(2);
        chk("R7 none pending", irq, 0);

        // R7: enable masking, one enabled pin at a time, all pins high
        pins = 32'hFFFF_FFFF;
        for (int k = 0; k < 32; k++) begin
            wr(A_EN_LO, (k < 16) ? 16'(32'd1 << k) : 16'h0);
            wr(A_EN_HI, (k >= 16) ? 16'(32'd1 << (k - 16)) : 16'h0);
            step(1);
            chk("R7 mask irq", irq, 1);
            chk("R7 mask idx", idx, k);
        end
        wr(A_EN_LO, 16'h00FF); wr(A_EN_HI, 16'h0000);
        pins = 32'h0001_FF00; step(2);
        chk("R7 masked low", irq, 0);
        wr(A_EN_HI, 16'h0001); step(1);
        chk("R8 high offset", idx, 16);
        chk("R8 high irq", irq, 1);

        // R4/R6: latched edges, per-bit edge select F=CCCC R=AAAA
        pins = '0; step(3);
        cfg_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hCCCC, 16'hAAAA);
        wr(A_STAT_LO, 16'hFFFF); wr(A_STAT_HI, 16'hFFFF);
        pins = 32'hFFFF_FFFF; step(3);
        rd(A_STAT_LO, d); chk("R6 rise lo", d, 16'hAAAA);
        rd(A_STAT_HI, d); chk("R6 rise hi", d, 16'hAAAA);
        chk("R8 latched idx", idx, 1);
        step(5);
        rd(A_STAT_LO, d); rd(A_STAT_LO, d2);
        chk("R4 persists", d, 16'hAAAA);
        chk("R10 read no side effect", d2, d);
        wr(A_STAT_LO, 16'h0000);
        rd(A_STAT_LO, d); chk("R4 write zero", d, 16'hAAAA);
        wr(A_STAT_LO, 16'hFFFF); wr(A_STAT_HI, 16'hFFFF);
        rd(A_STAT_LO, d); chk("R4 cleared", d, 0);
        chk("R7 cleared irq", irq, 0);
        pins = '0; step(3);
        rd(A_STAT_LO, d); chk("R6 fall lo", d, 16'hCCCC);
        rd(A_STAT_HI, d); chk("R6 fall hi", d, 16'hCCCC);
        wr(A_STAT_LO, 16'hFFFF); wr(A_STAT_HI, 16'hFFFF);

        // R5: pass-through edge pulse on every pin, rising only
        cfg_all(16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF);
        for (int p = 0; p < 32; p++) begin
            pins = '0; step(3);
            pins = 32'd1 << p;
            step(1);
            chk("R5 early", irq, 0);
            step(1);
            chk("R5 pulse", irq, 1);
            chk("R5 idx", idx, p);
            step(1);
            chk("R5 one cycle", irq, 0);
        end
        pins = '0; step(2);
        chk("R6 fall off", irq, 0);

        // R9: new edge in the same cycle as the clear
        pins = '0; step(3);
        cfg_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        wr(A_STAT_LO, 16'hFFFF); wr(A_STAT_HI, 16'hFFFF);
        pins = 32'h0000_0020; step(3);
        rd(A_STAT_LO, d); chk("R9 set", d, 16'h0020);
        pins = '0; step(2);
        wr(A_STAT_LO, 16'h0020);
        rd(A_STAT_LO, d); chk("R9 edge wins", d, 16'h0020);
        chk("R9 irq idx", idx, 5);
        wr(A_STAT_LO, 16'h0020);
        rd(A_STAT_LO, d); chk("R4 plain clear", d, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule